// File: doc/BRIEF.md
# Reconfigurable Integer Dataflow Matrix

This block executes one collapsed integer dataflow subgraph per invocation. Sixteen integer functional units sit in a fixed triangle of five rows. From top to bottom the rows hold 6, 4, 3, 2 and 1 units. One wide configuration word sets every unit's operation and both of its operand sources. The same word also chooses which external operands enter each row, which units drive the few long row-skip links, and which unit outputs become the six results.

The datapath between operand inputs and result selection is purely combinational. A controller holds the configuration word and the operands stable for as many cycles as the subgraph needs. It then pulses a capture strobe, and the selected unit outputs are stored in six result registers. Data only moves downward: from a row to the row below it, from a unit to its right-hand neighbour in rows 3 and 4, and over four long links that skip rows.

Top module: `fu_matrix`

## Requirements
- R1: Units are numbered 0 to 15, row by row from the top row and left to right within a row. Each unit has two operands, A and B. Each operand is chosen by a 5-bit code:
  - 0 to 5 select that unit of the row directly above;
  - 8 to 14 select that input lane of the unit's own row;
  - 16 and 17 select long links;
  - 18 selects the left-hand neighbour;
  - 19 selects the unit's 16-bit immediate, sign-extended.
  Any other code, or a code naming a source the unit does not have (for example row 1 above-row codes), gives zero.
- R2: Rows 1 to 5 have 7, 2, 2, 2 and 1 input lanes. Lanes are numbered 0 to 13 globally in row order. Each lane has a 3-bit code that picks one of the eight 32-bit operands.
- R3: There are four long links, each with a 3-bit source index:
  - link 0 runs from row 1 to row 3 (code 16);
  - link 1 runs from row 2 to row 4 (code 16);
  - link 2 runs from row 1 to row 4 (code 17);
  - link 3 runs from row 1 to row 5 (code 16).
  A source index at or beyond the width of the source row gives zero.
- R4: Code 18 selects the output of the unit to the left. This applies only to units 1 and 2 of row 3 and to unit 1 of row 4. Every other unit gets zero for code 18.
- R5: The 4-bit operation codes are: 0 pass, 1 and, 2 or, 3 xor, 4 nor, 5 add, 6 sub, 7 signed less-than, 8 unsigned less-than, 9 shift left, 10 logical shift right, 11 arithmetic shift right. Pass forwards operand A unchanged.
- R6: Operation classes are logic (1 to 4), arithmetic (5 to 8) and shift (9 to 11). Each row supports only some classes:
  - rows 1 and 3 support all three;
  - rows 2 and 5 support logic and arithmetic;
  - row 4 supports logic and shift.
  An operation outside its row's classes gives zero, and so do codes 12 to 15.
- R7: Shifts use B[4:0] as the amount. Comparisons return 0 or 1.
- R8: Each of the six results has a 4-bit unit index. Any unit may feed any result, and one unit may feed several results.
- R9: The results change only at a rising clock edge where the capture strobe is high. At any other edge they hold their values.
- R10: A synchronous active-high reset clears all results, and it takes priority over capture.
- R11: The configuration fields sit at these bit positions:
  - unit u occupies bits [30u+29:30u], laid out as {imm[15:0], B code, A code, op};
  - lane l occupies bits [480+3l+2:480+3l];
  - link k occupies bits [522+3k+2:522+3k];
  - result k occupies bits [534+4k+3:534+4k].
  The word is 558 bits wide in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_i | input | 558 | Configuration word |
| opnd_i | input | 256 | Eight 32-bit operands, operand n at [32n+31:32n] |
| cap_i | input | 1 | Capture strobe for the result registers |
| res_o | output | 192 | Six 32-bit results, result k at [32k+31:32k] |

## Verification
The clocked checks take the capture strobe and reset to be clean, synchronous 2-state levels. The immediate checks on each unit assume that the configuration and operands are settled whenever they are evaluated. The stimulus therefore changes the configuration, the operands and the strobe only at falling edges, and it raises the strobe for exactly one cycle after the inputs have settled. The routing tests use configurations whose every chain through the triangle has hand-computed values. Those values cover negative operands, zero shift amounts and out-of-range source indices.

// File: rtl/fu_matrix_pkg.sv
`timescale 1ns/1ps
package fu_matrix_pkg;

  localparam int NROW   = 5;
  localparam int MAXU   = 6;
  localparam int MAXL   = 7;
  localparam int NUNIT  = 16;
  localparam int NLANE  = 14;
  localparam int NLINK  = 4;
  localparam int OPW    = 4;
  localparam int SELW   = 5;

  localparam int SEL_LANE0 = 8;
  localparam int SEL_LONG0 = 16;
  localparam int SEL_NBR   = 18;
  localparam int SEL_IMM   = 19;

  localparam logic [2:0] CLS_LOGIC = 3'b001;
  localparam logic [2:0] CLS_ARITH = 3'b010;
  localparam logic [2:0] CLS_SHIFT = 3'b100;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 4'd0,  OP_AND = 4'd1,  OP_OR  = 4'd2,  OP_XOR  = 4'd3,
    OP_NOR  = 4'd4,  OP_ADD = 4'd5,  OP_SUB = 4'd6,  OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,  OP_SLL = 4'd9,  OP_SRL = 4'd10, OP_SRA  = 4'd11
  } fu_op_e;

  function automatic int row_units(input int r);
    case (r)
      0: return 6;
      1: return 4;
      2: return 3;
      3: return 2;
      4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int row_lanes(input int r);
    case (r)
      0: return 7;
      1, 2, 3: return 2;
      4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int unit_base(input int r);
    int s;
    s = 0;
    for (int i = 0; i < r; i++) s += row_units(i);
    return s;
  endfunction

  function automatic int lane_base(input int r);
    int s;
    s = 0;
    for (int i = 0; i < r; i++) s += row_lanes(i);
    return s;
  endfunction

  function automatic logic [2:0] row_classes(input int r);
    case (r)
      0, 2: return CLS_LOGIC | CLS_ARITH | CLS_SHIFT;
      1, 4: return CLS_LOGIC | CLS_ARITH;
      3:    return CLS_LOGIC | CLS_SHIFT;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int row_nlong(input int r);
    case (r)
      2, 4: return 1;
      3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit row_has_nbr(input int r);
    return (r == 2) || (r == 3);
  endfunction

  // source row of each long link, indexed by link number
  function automatic int link_src(input int k);
    return (k == 1) ? 1 : 0;
  endfunction

endpackage

// File: rtl/fu_alu.sv
`timescale 1ns/1ps
module fu_alu
  import fu_matrix_pkg::*;
#(
  parameter int         DW  = 32,
  parameter logic [2:0] CLS = 3'b111
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  y_o
);

  localparam int SHW = $clog2(DW);

  fu_op_e          op;
  logic [SHW-1:0]  shamt;
  logic [2:0]      need;
  logic [DW-1:0]   raw;

  always_comb begin
    op    = fu_op_e'(op_i);
    shamt = b_i[SHW-1:0];
    need  = 3'b000;
    raw   = '0;
    case (op)
      OP_PASS: raw = a_i;
      OP_AND:  begin need = CLS_LOGIC; raw = a_i & b_i;    end
      OP_OR:   begin need = CLS_LOGIC; raw = a_i | b_i;    end
      OP_XOR:  begin need = CLS_LOGIC; raw = a_i ^ b_i;    end
      OP_NOR:  begin need = CLS_LOGIC; raw = ~(a_i | b_i); end
      OP_ADD:  begin need = CLS_ARITH; raw = a_i + b_i;    end
      OP_SUB:  begin need = CLS_ARITH; raw = a_i - b_i;    end
      OP_SLT:  begin need = CLS_ARITH; raw = DW'($signed(a_i) < $signed(b_i)); end
      OP_SLTU: begin need = CLS_ARITH; raw = DW'(a_i < b_i); end
      OP_SLL:  begin need = CLS_SHIFT; raw = a_i << shamt; end
      OP_SRL:  begin need = CLS_SHIFT; raw = a_i >> shamt; end
      OP_SRA:  begin need = CLS_SHIFT; raw = $signed(a_i) >>> shamt; end
      default: raw = '0;
    endcase
    y_o = ((need == 3'b000) || ((need & CLS) != 3'b000)) ? raw : '0;
  end

  // R5: a pass-through unit forwards A unchanged
  always_comb begin
    if (op_i == OP_PASS) a_r5_pass: assert (y_o == a_i);
  end

  // R6: a row without the shift class yields zero for any shift
  always_comb begin
    if (!CLS[2] && (op_i inside {OP_SLL, OP_SRL, OP_SRA}))
      a_r6_no_shift: assert (y_o == '0);
  end

  // R7: comparisons produce a single-bit truth value
  always_comb begin
    if (op_i inside {OP_SLT, OP_SLTU}) a_r7_cmp_bit: assert (y_o[DW-1:1] == '0);
  end

endmodule

// File: rtl/fu_cell.sv
`timescale 1ns/1ps
module fu_cell
  import fu_matrix_pkg::*;
#(
  parameter int         DW    = 32,
  parameter int         IMMW  = 16,
  parameter logic [2:0] CLS   = 3'b111,
  parameter int         NPREV = 0,
  parameter int         NLN   = 7,
  parameter int         NLONG = 0,
  parameter bit         NBR   = 1'b0,
  parameter int         UCW   = OPW + 2*SELW + IMMW
) (
  input  logic [UCW-1:0]     cfg_i,
  input  logic [MAXU*DW-1:0] prev_i,
  input  logic [MAXL*DW-1:0] lane_i,
  input  logic [2*DW-1:0]    long_i,
  input  logic [DW-1:0]      nbr_i,
  output logic [DW-1:0]      y_o
);

  logic [OPW-1:0]  op;
  logic [SELW-1:0] sel_a, sel_b;
  logic [IMMW-1:0] imm;
  logic [DW-1:0]   imm_x, opa, opb;

  assign op    = cfg_i[OPW-1:0];
  assign sel_a = cfg_i[OPW +: SELW];
  assign sel_b = cfg_i[OPW+SELW +: SELW];
  assign imm   = cfg_i[OPW+2*SELW +: IMMW];
  assign imm_x = {{(DW-IMMW){imm[IMMW-1]}}, imm};

  function automatic logic [DW-1:0] pick(
    input logic [SELW-1:0]    s,
    input logic [MAXU*DW-1:0] pv,
    input logic [MAXL*DW-1:0] lv,
    input logic [2*DW-1:0]    gv,
    input logic [DW-1:0]      nv,
    input logic [DW-1:0]      iv
  );
    int i;
    logic [DW-1:0] v;
    i = int'(s);
    v = '0;
    if (i < MAXU) begin
      if (i < NPREV) v = pv[i*DW +: DW];
    end else if (i >= SEL_LANE0 && i < SEL_LANE0 + MAXL) begin
      if (i - SEL_LANE0 < NLN) v = lv[(i-SEL_LANE0)*DW +: DW];
    end else if (i == SEL_LONG0) begin
      if (NLONG > 0) v = gv[DW-1:0];
    end else if (i == SEL_LONG0 + 1) begin
      if (NLONG > 1) v = gv[2*DW-1:DW];
    end else if (i == SEL_NBR) begin
      if (NBR) v = nv;
    end else if (i == SEL_IMM) begin
      v = iv;
    end
    return v;
  endfunction

  always_comb begin
    opa = pick(sel_a, prev_i, lane_i, long_i, nbr_i, imm_x);
    opb = pick(sel_b, prev_i, lane_i, long_i, nbr_i, imm_x);
  end

  fu_alu #(.DW(DW), .CLS(CLS)) u_alu (
    .op_i (op),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (y_o)
  );

endmodule

// File: rtl/fu_row.sv
`timescale 1ns/1ps
module fu_row
  import fu_matrix_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IMMW = 16,
  parameter int ROW  = 0,
  parameter int NU   = row_units(ROW),
  parameter int UCW  = OPW + 2*SELW + IMMW
) (
  input  logic [NU*UCW-1:0]  cfg_i,
  input  logic [MAXU*DW-1:0] prev_i,
  input  logic [MAXL*DW-1:0] lane_i,
  input  logic [2*DW-1:0]    long_i,
  output logic [NU*DW-1:0]   y_o
);

  localparam int         NPREV = (ROW == 0) ? 0 : row_units(ROW - 1);
  localparam int         NLN   = row_lanes(ROW);
  localparam int         NLONG = row_nlong(ROW);
  localparam logic [2:0] CLS   = row_classes(ROW);

  logic [DW-1:0] yv [NU];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic [DW-1:0] nbr;
    if (row_has_nbr(ROW) && u > 0) begin : g_nbr
      assign nbr = yv[u-1];
    end else begin : g_no_nbr
      assign nbr = '0;
    end

    fu_cell #(
      .DW(DW), .IMMW(IMMW), .CLS(CLS), .NPREV(NPREV), .NLN(NLN),
      .NLONG(NLONG), .NBR(row_has_nbr(ROW) && u > 0), .UCW(UCW)
    ) u_cell (
      .cfg_i  (cfg_i[u*UCW +: UCW]),
      .prev_i (prev_i),
      .lane_i (lane_i),
      .long_i (long_i),
      .nbr_i  (nbr),
      .y_o    (yv[u])
    );

    assign y_o[u*DW +: DW] = yv[u];
  end

endmodule

// File: rtl/fu_matrix.sv
`timescale 1ns/1ps
module fu_matrix
  import fu_matrix_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NIN  = 8,
  parameter int NRES = 6,
  parameter int IMMW = 16,
  parameter int UCW      = OPW + 2*SELW + IMMW,
  parameter int LSELW    = $clog2(NIN),
  parameter int LNKW     = $clog2(MAXU),
  parameter int USELW    = $clog2(NUNIT),
  parameter int LANE_OFS = NUNIT * UCW,
  parameter int LINK_OFS = LANE_OFS + NLANE * LSELW,
  parameter int RES_OFS  = LINK_OFS + NLINK * LNKW,
  parameter int CFGW     = RES_OFS + NRES * USELW
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [CFGW-1:0]      cfg_i,
  input  logic [NIN*DW-1:0]    opnd_i,
  input  logic                 cap_i,
  output logic [NRES*DW-1:0]   res_o
);

  localparam int PW = MAXU * DW;

  logic [DW-1:0]      lane_v [NLANE];
  logic [DW-1:0]      link_v [NLINK];
  logic [DW-1:0]      unit_y [NUNIT];
  logic [PW-1:0]      row_y  [NROW];
  logic [NRES*DW-1:0] res_q;

  // operand lanes: each lane picks one external operand
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [LSELW-1:0] s;
    assign s = cfg_i[LANE_OFS + l*LSELW +: LSELW];
    assign lane_v[l] = (int'(s) < NIN) ? opnd_i[s*DW +: DW] : '0;
  end

  // long row-skip links: each one picks one unit of its source row
  for (genvar k = 0; k < NLINK; k++) begin : g_link
    logic [LNKW-1:0] s;
    assign s = cfg_i[LINK_OFS + k*LNKW +: LNKW];
    assign link_v[k] = (int'(s) < row_units(link_src(k))) ?
                       row_y[link_src(k)][s*DW +: DW] : '0;
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam int NU = row_units(r);
    logic [NU*DW-1:0]   y;
    logic [PW-1:0]      prev;
    logic [MAXL*DW-1:0] lanes;
    logic [2*DW-1:0]    lng;

    if (r == 0) begin : g_top
      assign prev = '0;
    end else begin : g_below
      assign prev = row_y[r-1];
    end

    for (genvar k = 0; k < MAXL; k++) begin : g_ln
      if (k < row_lanes(r)) begin : g_on
        assign lanes[k*DW +: DW] = lane_v[lane_base(r) + k];
      end else begin : g_off
        assign lanes[k*DW +: DW] = '0;
      end
    end

    if (r == 2) begin : g_l3
      assign lng = {{DW{1'b0}}, link_v[0]};
    end else if (r == 3) begin : g_l4
      assign lng = {link_v[2], link_v[1]};
    end else if (r == 4) begin : g_l5
      assign lng = {{DW{1'b0}}, link_v[3]};
    end else begin : g_lnone
      assign lng = '0;
    end

    fu_row #(.DW(DW), .IMMW(IMMW), .ROW(r), .NU(NU), .UCW(UCW)) u_row (
      .cfg_i  (cfg_i[unit_base(r)*UCW +: NU*UCW]),
      .prev_i (prev),
      .lane_i (lanes),
      .long_i (lng),
      .y_o    (y)
    );

    assign row_y[r] = PW'(y);

    for (genvar u = 0; u < NU; u++) begin : g_out
      assign unit_y[unit_base(r) + u] = y[u*DW +: DW];
    end
  end

  // result registers, loaded on the capture strobe
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_q <= '0;
    end else if (cap_i) begin
      for (int k = 0; k < NRES; k++)
        res_q[k*DW +: DW] <= unit_y[cfg_i[RES_OFS + k*USELW +: USELW]];
    end
  end

  assign res_o = res_q;

  // R9: without a strobe the results hold
  a_r9_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !cap_i |=> $stable(res_o));

  // R10: reset clears every result
  a_r10_clear: assert property (@(posedge clk_i)
    rst_i |=> (res_o == '0));

endmodule

// File: tb/sim_fu_matrix.sv
`timescale 1ns/1ps
module sim_fu_matrix;
  import fu_matrix_pkg::*;

  localparam int DW = 32, NIN = 8, NRES = 6, IMMW = 16;
  localparam int UCW      = 30;
  localparam int LANE_OFS = 480;
  localparam int LINK_OFS = 522;
  localparam int RES_OFS  = 534;
  localparam int CFGW     = 558;

  // eight operands then six expected results (units 15,12,11,9,7,1)
  localparam logic [31:0] VEC [3][14] = '{
    '{32'd10, 32'd20, 32'd100, 32'd3, 32'h0F, 32'h12, 32'd5, 32'd1,
      32'h42, 32'h8, 32'h8B, 32'h0, 32'hF1, 32'h61},
    '{32'hFFFFFFFB, 32'd2, 32'd0, 32'd1, 32'hFFFFFF00, 32'h80000001, 32'd0, 32'h10,
      32'h5, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'h0, 32'hF, 32'hFFFFFFFF},
    '{32'd7, 32'd7, 32'h1000, 32'h20, 32'd0, 32'd0, 32'h100, 32'd0,
      32'hE, 32'hE1, 32'hE11, 32'h0, 32'hFF, 32'hFE0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cap = 1'b0;
  logic [CFGW-1:0]   cfg = '0;
  logic [NIN*DW-1:0] opnd = '0;
  logic [NRES*DW-1:0] res;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  fu_matrix #(.DW(DW), .NIN(NIN), .NRES(NRES), .IMMW(IMMW)) u0 (
    .clk_i(clk), .rst_i(rst), .cfg_i(cfg), .opnd_i(opnd), .cap_i(cap), .res_o(res)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rw(input int k);
    return res[k*DW +: DW];
  endfunction

  task automatic set_unit(input int u, input int op, input int sa, input int sb, input int imm);
    cfg[u*UCW +: UCW] = {16'(imm), 5'(sb), 5'(sa), 4'(op)};
  endtask
  task automatic set_lane(input int l, input int s); cfg[LANE_OFS + 3*l +: 3] = 3'(s); endtask
  task automatic set_link(input int k, input int s); cfg[LINK_OFS + 3*k +: 3] = 3'(s); endtask
  task automatic set_res (input int k, input int u); cfg[RES_OFS + 4*k +: 4] = 4'(u); endtask

  task automatic load_vec(input int n);
    for (int i = 0; i < 8; i++) opnd[i*DW +: DW] = VEC[n][i];
  endtask

  task automatic do_cap;
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
  endtask

  task automatic cfg_a;
    cfg = '0;
    for (int k = 0; k < 7; k++) set_lane(k, k);
    set_lane(7, 7); set_lane(8, 0); set_lane(9, 1); set_lane(10, 2);
    set_lane(11, 3); set_lane(12, 4); set_lane(13, 5);
    set_unit(0, 5, 8, 9, 0);     set_unit(1, 6, 10, 11, 0);
    set_unit(2, 3, 12, 19, 'hFF); set_unit(3, 9, 13, 19, 4);
    set_unit(4, 0, 14, 0, 0);    set_unit(5, 7, 8, 9, 0);
    set_unit(6, 2, 0, 1, 0);     set_unit(7, 5, 2, 8, 0);
    set_unit(8, 1, 3, 19, 'h0FF0); set_unit(9, 9, 4, 19, 1);
    set_unit(10, 6, 0, 16, 0);   set_unit(11, 3, 18, 1, 0);
    set_unit(12, 11, 18, 19, 4);
    set_unit(13, 2, 16, 17, 0);  set_unit(14, 10, 18, 8, 0);
    set_unit(15, 5, 1, 16, 0);
    set_link(0, 4); set_link(1, 2); set_link(2, 5); set_link(3, 0);
    set_res(0, 15); set_res(1, 12); set_res(2, 11);
    set_res(3, 9);  set_res(4, 7);  set_res(5, 1);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R9 actual=running expected=done");
    finish_run();
  end

  initial begin
    string tags [6];
    tags = '{"R3", "R7", "R4", "R6", "R2", "R11"};
    cfg_a();
    repeat (3) @(negedge clk);
    for (int k = 0; k < NRES; k++) chk("R10 reset state", rw(k), 32'h0);
    rst = 1'b0;

    // table walk: routing across all rows under configuration A
    for (int n = 0; n < 3; n++) begin
      load_vec(n);
      do_cap();
      for (int k = 0; k < NRES; k++) chk(tags[k], rw(k), VEC[n][8+k]);
    end

    // R9: new operands without a strobe leave results untouched
    load_vec(0);
    repeat (3) @(negedge clk);
    chk("R9 hold", rw(0), 32'hE);
    chk("R9 hold", rw(2), 32'hE11);
    do_cap();
    chk("R9 capture", rw(0), 32'h42);

    // directed corners on configuration B
    set_unit(15, 15, 1, 16, 0);
    set_res(1, 4); set_res(2, 4);
    set_link(1, 6); set_res(3, 13);
    set_unit(6, 2, 0, 25, 0); set_res(4, 6);
    set_unit(7, 5, 2, 18, 0); set_res(5, 7);
    do_cap();
    chk("R6 undefined op", rw(0), 32'h0);
    chk("R5 pass", rw(1), 32'd5);
    chk("R8 shared unit", rw(2), 32'd5);
    chk("R3 link range / R7 slt", rw(3), 32'd1);
    chk("R1 unused code", rw(4), 32'h1E);
    chk("R4 no neighbour", rw(5), 32'hF0);

    // R10: reset beats a simultaneous strobe
    @(negedge clk); rst = 1'b1; cap = 1'b1;
    @(negedge clk); rst = 1'b0; cap = 1'b0;
    for (int k = 0; k < NRES; k++) chk("R10 reset over capture", rw(k), 32'h0);

    finish_run();
  end

endmodule